// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This peripheral keeps time as a single 32-bit count of elapsed seconds. A one-cycle pulse on `sec_tick`, produced elsewhere from a slow reference, advances the count by one whenever the run bit in the control register is set. Software can preload the count, and it can program a compare value. When a tick moves the count onto that value, the block latches an alarm event.

The alarm event sits in a sticky raw status bit. An enable bit gates it into a masked status bit, and the masked bits drive the level interrupt line. Software acknowledges the event by writing a one to the matching bit of a write-one-to-clear register. All registers are reached over a single-cycle bus. Writes take effect at the next clock edge. Read data is a combinational function of the byte address and the current register state.

Top module: `wallclock_rtc`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, compare value, preload value, run bit, alarm enable and raw status all become zero, so every register reads 0 and `alarm_irq` is low.
- R2: A write to offset 0x08 loads the written value into the count at that edge. A read of offset 0x00 returns the count. A preload wins over a tick in the same cycle.
- R3: With control bit 26 set, each cycle with `sec_tick` high raises the count by one at the next edge. The count wraps from 0xFFFFFFFF to 0.
- R4: With control bit 26 clear, ticks leave the count unchanged.
- R5: Bit 0 of the raw status register (offset 0x14) is set when a tick advances the count to a value equal to the compare register (offset 0x04). A preload that lands on the compare value does not set it.
- R6: The raw alarm bit stays set whatever the enable bit is, until a write to offset 0x1C has bit 0 at one. A write with bit 0 at zero leaves it set. If a tick sets the bit in the same cycle as a clear, the bit ends up set.
- R7: Bit 0 of offset 0x18 reads as raw bit 0 ANDed with enable bit 0 at offset 0x10. `alarm_irq` is high exactly when a masked bit is set.
- R8: The compare value (offset 0x04) and the last preload value (offset 0x08) read back in full. Offset 0x10 reads back only bit 0, and offset 0x0C reads back only bit 26.
- R9: Offsets other than those listed above, offset 0x1C and unaligned addresses all read zero. Writes to offsets 0x00, 0x14 and 0x18 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sec_tick | input | 1 | One-cycle pulse, once per second |
| reg_addr | input | 8 | Byte address of the access |
| reg_wr | input | 1 | Write strobe for this cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| alarm_irq | output | 1 | Level interrupt, OR of the masked status bits |

## Verification
The assertions check on every cycle that:
- the count moves only by a preload, by a gated increment, or not at all;
- the raw alarm bit rises only after a tick that lands on the compare value;
- the raw bit falls only on a clear write;
- the interrupt never fires without an enabled raw bit;
- unmapped reads return zero.

Only the bench scenarios can show some other behaviours: the priority of a set over a simultaneous clear, the wrap of the count, the rule that a preload onto the compare value raises nothing, and the read-back masking of the control and enable registers. They are checked against a behavioural model of the register file.

// File: rtl/rtc_regs_pkg.sv
// Package: register offsets and fixed field positions of the seconds RTC.
// Assumes byte addressing with 32-bit registers on 4-byte boundaries.
package rtc_regs_pkg;
    localparam int unsigned RTC_DW  = 32;
    localparam int unsigned RTC_AW  = 8;
    localparam int unsigned RUN_BIT = 26;

    localparam logic [7:0] OFS_COUNT = 8'h00;
    localparam logic [7:0] OFS_MATCH = 8'h04;
    localparam logic [7:0] OFS_LOAD  = 8'h08;
    localparam logic [7:0] OFS_CTRL  = 8'h0C;
    localparam logic [7:0] OFS_MASK  = 8'h10;
    localparam logic [7:0] OFS_RAW   = 8'h14;
    localparam logic [7:0] OFS_MSTAT = 8'h18;
    localparam logic [7:0] OFS_CLEAR = 8'h1C;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_COUNT, SEL_MATCH, SEL_LOAD,
        SEL_CTRL, SEL_MASK,  SEL_RAW,   SEL_MSTAT, SEL_CLEAR
    } reg_sel_e;
endpackage

// File: rtl/rtc_reg_bank.sv
// Register bank: decodes the byte address, holds the writable registers and
// forms the read data. Assumes single-cycle accesses; writes land at the edge.
module rtc_reg_bank
    import rtc_regs_pkg::*;
#(
    parameter int unsigned DW      = RTC_DW,
    parameter int unsigned AW      = RTC_AW,
    parameter int unsigned IRQ_W   = 1,
    parameter int unsigned RUN_POS = RUN_BIT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr,
    input  logic             wr,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    count,
    input  logic [IRQ_W-1:0] raw,
    input  logic [IRQ_W-1:0] masked,
    output logic             load_we,
    output logic [IRQ_W-1:0] clr_vec,
    output logic [DW-1:0]    match_q,
    output logic [IRQ_W-1:0] mask_q,
    output logic             run_q,
    output logic [DW-1:0]    rdata
);
    reg_sel_e        sel;
    logic [DW-1:0]   load_q;

    // Address decode: full byte compare, so unaligned addresses select nothing.
    always_comb begin
        unique case (addr)
            AW'(OFS_COUNT): sel = SEL_COUNT;
            AW'(OFS_MATCH): sel = SEL_MATCH;
            AW'(OFS_LOAD):  sel = SEL_LOAD;
            AW'(OFS_CTRL):  sel = SEL_CTRL;
            AW'(OFS_MASK):  sel = SEL_MASK;
            AW'(OFS_RAW):   sel = SEL_RAW;
            AW'(OFS_MSTAT): sel = SEL_MSTAT;
            AW'(OFS_CLEAR): sel = SEL_CLEAR;
            default:        sel = SEL_NONE;
        endcase
    end

    // Strobes toward the counter and the status logic.
    always_comb begin
        load_we = wr && (sel == SEL_LOAD);
        clr_vec = (wr && (sel == SEL_CLEAR)) ? wdata[IRQ_W-1:0] : '0;
    end

    // Writable register storage; read-only offsets have no write path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q <= '0;
            load_q  <= '0;
            mask_q  <= '0;
            run_q   <= 1'b0;
        end else if (wr) begin
            case (sel)
                SEL_MATCH: match_q <= wdata;
                SEL_LOAD:  load_q  <= wdata;
                SEL_MASK:  mask_q  <= wdata[IRQ_W-1:0];
                SEL_CTRL:  run_q   <= wdata[RUN_POS];
                default:   ;
            endcase
        end
    end

    // Read mux: unimplemented bits and unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_COUNT: rdata = count;
            SEL_MATCH: rdata = match_q;
            SEL_LOAD:  rdata = load_q;
            SEL_CTRL:  rdata[RUN_POS] = run_q;
            SEL_MASK:  rdata[IRQ_W-1:0] = mask_q;
            SEL_RAW:   rdata[IRQ_W-1:0] = raw;
            SEL_MSTAT: rdata[IRQ_W-1:0] = masked;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_sec_counter.sv
// Seconds counter: preloadable, advances on a gated tick, wraps modulo 2^DW.
// Flags a compare hit only when a tick (not a preload) lands on the match value.
module rtc_sec_counter #(
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          load_we,
    input  logic [DW-1:0] load_val,
    input  logic [DW-1:0] match,
    output logic [DW-1:0] count_q,
    output logic          hit
);
    logic          step;
    logic [DW-1:0] count_inc;

    // Next-value and hit detection against the current compare value.
    always_comb begin
        step      = tick && run;
        count_inc = count_q + DW'(1);
        hit       = step && !load_we && (count_inc == match);
    end

    // Count register: preload has priority over the increment.
    always_ff @(posedge clk) begin
        if (!rst_n)       count_q <= '0;
        else if (load_we) count_q <= load_val;
        else if (step)    count_q <= count_inc;
    end
endmodule

// File: rtl/rtc_irq_status.sv
// Interrupt status: one sticky raw bit per source, write-one-to-clear,
// masked view and a level interrupt. A set beats a clear in the same cycle.
module rtc_irq_status #(
    parameter int unsigned IRQ_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IRQ_W-1:0] set_vec,
    input  logic [IRQ_W-1:0] clr_vec,
    input  logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] raw_q,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    for (genvar i = 0; i < IRQ_W; i++) begin : g_src
        // Sticky raw bit for source i.
        always_ff @(posedge clk) begin
            if (!rst_n)          raw_q[i] <= 1'b0;
            else if (set_vec[i]) raw_q[i] <= 1'b1;
            else if (clr_vec[i]) raw_q[i] <= 1'b0;
        end
    end

    // Masked view and the level output.
    always_comb begin
        masked = raw_q & mask;
        irq    = |masked;
    end
endmodule

// File: rtl/wallclock_rtc.sv
// Top of the seconds RTC: ties the register bank, counter and status together.
// Assumes sec_tick is already synchronous to clk and lasts one cycle per second.
module wallclock_rtc
    import rtc_regs_pkg::*;
#(
    parameter int unsigned DW = RTC_DW,
    parameter int unsigned AW = RTC_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sec_tick,
    input  logic [AW-1:0] reg_addr,
    input  logic          reg_wr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          alarm_irq
);
    localparam int unsigned IRQ_W = 1;

    logic             load_we;
    logic [IRQ_W-1:0] clr_vec;
    logic [DW-1:0]    match_q;
    logic [IRQ_W-1:0] mask_q;
    logic             run_q;
    logic [DW-1:0]    count_q;
    logic             hit;
    logic [IRQ_W-1:0] set_vec;
    logic [IRQ_W-1:0] raw_q;
    logic [IRQ_W-1:0] masked;

    assign set_vec = IRQ_W'(hit);

    rtc_reg_bank #(.DW(DW), .AW(AW), .IRQ_W(IRQ_W), .RUN_POS(RUN_BIT)) u_bank (
        .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .wdata(reg_wdata),
        .count(count_q), .raw(raw_q), .masked(masked),
        .load_we(load_we), .clr_vec(clr_vec), .match_q(match_q),
        .mask_q(mask_q), .run_q(run_q), .rdata(reg_rdata)
    );

    rtc_sec_counter #(.DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .run(run_q),
        .load_we(load_we), .load_val(reg_wdata), .match(match_q),
        .count_q(count_q), .hit(hit)
    );

    rtc_irq_status #(.IRQ_W(IRQ_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
        .mask(mask_q), .raw_q(raw_q), .masked(masked), .irq(alarm_irq)
    );
endmodule

// File: rtl/rtc_checker.sv
// Checker for the seconds RTC, bound to the top; observes ports and key state.
module rtc_checker
    import rtc_regs_pkg::*;
#(
    parameter int unsigned DW = RTC_DW,
    parameter int unsigned AW = RTC_AW
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sec_tick,
    input logic [AW-1:0] reg_addr,
    input logic          reg_wr,
    input logic [DW-1:0] reg_wdata,
    input logic [DW-1:0] reg_rdata,
    input logic          alarm_irq,
    input logic [DW-1:0] count,
    input logic [DW-1:0] match,
    input logic          mask0,
    input logic          raw0,
    input logic          run
);
    logic load_wr, clr_wr, mapped;
    always_comb begin
        load_wr = reg_wr && (reg_addr == AW'(OFS_LOAD));
        clr_wr  = reg_wr && (reg_addr == AW'(OFS_CLEAR)) && reg_wdata[0];
        mapped  = (reg_addr == AW'(OFS_COUNT)) || (reg_addr == AW'(OFS_MATCH)) ||
                  (reg_addr == AW'(OFS_LOAD))  || (reg_addr == AW'(OFS_CTRL))  ||
                  (reg_addr == AW'(OFS_MASK))  || (reg_addr == AW'(OFS_RAW))   ||
                  (reg_addr == AW'(OFS_MSTAT));
    end

    a_r2_load_takes: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> count == $past(reg_wdata));

    a_r3_tick_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && run && !load_wr) |=> count == $past(count) + DW'(1));

    a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!(sec_tick && run) && !load_wr) |=> $stable(count));

    a_r5_rise_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw0) |-> ($past(sec_tick) && count == $past(match)));

    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw0 && !clr_wr) |=> raw0);

    a_r7_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (raw0 && mask0));

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> reg_rdata == '0);
endmodule

bind wallclock_rtc rtc_checker #(.DW(DW), .AW(AW)) u_rtc_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .alarm_irq(alarm_irq), .count(count_q), .match(match_q),
    .mask0(mask_q[0]), .raw0(raw_q[0]), .run(run_q)
);

// File: tb/test_wallclock_rtc.sv
`timescale 1ns/1ps
// Bench: behavioural reference of the register file, compared every clock.
module test_wallclock_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        alarm_irq;

    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_cnt = 0, m_match = 0, m_load = 0;
    bit m_run = 0, m_mask = 0, m_raw = 0;

    always #2.5 clk = ~clk;

    wallclock_rtc i_wallclock_rtc (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .alarm_irq(alarm_irq)
    );

    function automatic logic [31:0] model_read(input logic [7:0] a);
        case (a)
            8'h00: return m_cnt;
            8'h04: return m_match;
            8'h08: return m_load;
            8'h0C: return m_run ? 32'h0400_0000 : 32'h0;
            8'h10: return {31'b0, m_mask};
            8'h14: return {31'b0, m_raw};
            8'h18: return {31'b0, m_raw & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at negedge, compare the comb outputs, then advance the model.
    task automatic step(input bit tk, input bit wr, input logic [7:0] a,
                        input logic [31:0] wd, input string tag);
        bit ld, inc, set, clr;
        @(negedge clk);
        sec_tick = tk; reg_wr = wr; reg_addr = a; reg_wdata = wd;
        #1;
        if (rst_n) begin
            check({tag, " rdata"}, reg_rdata, model_read(a));
            check({tag, " irq (R7)"}, {31'b0, alarm_irq}, {31'b0, m_raw & m_mask});
        end
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = 0; m_match = 0; m_load = 0; m_run = 0; m_mask = 0; m_raw = 0;
        end else begin
            ld  = wr && a == 8'h08;
            inc = tk && m_run;
            set = !ld && inc && (m_cnt + 1 == m_match);
            clr = wr && a == 8'h1C && wd[0];
            if (ld) m_cnt = wd; else if (inc) m_cnt = m_cnt + 1;
            if (set) m_raw = 1; else if (clr) m_raw = 0;
            if (wr && a == 8'h04) m_match = wd;
            if (wr && a == 8'h08) m_load = wd;
            if (wr && a == 8'h10) m_mask = wd[0];
            if (wr && a == 8'h0C) m_run = wd[26];
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d, input string tag);
        step(0, 1, a, d, tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1, 0, 8'h00, 0, tag);
    endtask

    // Read with a literal expectation in addition to the model comparison.
    task automatic lit(input logic [7:0] a, input logic [31:0] exp, input string tag);
        step(0, 0, a, 0, tag);
        check({tag, " literal"}, reg_rdata, exp);
    endtask

    initial begin
        repeat (3) step(0, 0, 8'h00, 0, "R1 reset");
        rst_n = 1'b1;
        // R1: all registers zero after reset
        for (int a = 0; a < 32; a += 4) lit(8'(a), 32'h0, "R1");

        wr_reg(8'h0C, 32'h0400_0000, "R8");
        lit(8'h0C, 32'h0400_0000, "R8");
        wr_reg(8'h08, 32'd10, "R2");
        lit(8'h00, 32'd10, "R2");
        lit(8'h08, 32'd10, "R8");
        ticks(3, "R3");
        lit(8'h00, 32'd13, "R3");

        wr_reg(8'h04, 32'd15, "R8");
        lit(8'h04, 32'd15, "R8");
        ticks(2, "R5");
        lit(8'h14, 32'd1, "R5");
        lit(8'h18, 32'd0, "R7");
        wr_reg(8'h1C, 32'h0, "R6");
        lit(8'h14, 32'd1, "R6");
        wr_reg(8'h10, 32'h1, "R7");
        lit(8'h18, 32'd1, "R7");
        check("R7 irq high", {31'b0, alarm_irq}, 32'd1);
        wr_reg(8'h1C, 32'h1, "R6");
        lit(8'h14, 32'd0, "R6");

        wr_reg(8'h0C, 32'h0, "R4");
        ticks(4, "R4");
        lit(8'h00, 32'd15, "R4");
        wr_reg(8'h08, 32'd15, "R5");
        lit(8'h14, 32'd0, "R5");

        wr_reg(8'h00, 32'd99, "R9");
        wr_reg(8'h14, 32'hFFFF_FFFF, "R9");
        wr_reg(8'h18, 32'hFFFF_FFFF, "R9");
        lit(8'h00, 32'd15, "R9");
        lit(8'h14, 32'd0, "R9");
        lit(8'h02, 32'd0, "R9");
        lit(8'h20, 32'd0, "R9");
        lit(8'h1C, 32'd0, "R9");

        wr_reg(8'h0C, 32'h0400_0000, "R3");
        wr_reg(8'h08, 32'hFFFF_FFFE, "R3");
        ticks(2, "R3");
        lit(8'h00, 32'd0, "R3");

        wr_reg(8'h04, 32'd1, "R6");
        step(1, 1, 8'h1C, 32'h1, "R6");
        lit(8'h14, 32'd1, "R6");

        step(1, 1, 8'h08, 32'd50, "R2");
        lit(8'h00, 32'd50, "R2");

        wr_reg(8'h10, 32'hFFFF_FFFF, "R8");
        lit(8'h10, 32'd1, "R8");
        wr_reg(8'h0C, 32'hFFFF_FFFF, "R8");
        lit(8'h0C, 32'h0400_0000, "R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule